// File: doc/BRIEF.md
# HD Pixel Input Timing and Luma/Chroma Alignment

This block sits at the entry of a high-definition video pipeline. It takes 8-bit luma on one bus and chroma on a second bus. The chroma bus carries Cb and Cr interleaved sample by sample in 4:2:2 mode. In 4:4:4 mode it carries Cb while a third bus carries Cr. The block also receives a horizontal sync, a vertical input that is either a VSYNC pulse or a field-identity level, and a blanking flag. It keeps a sample counter and a line counter. In automatic mode these counters run to the totals of the selected standard. In external mode they follow the incoming syncs.

The interleaved chroma is split into Cb and Cr. The order is anchored to the falling edge of the horizontal sync, and each split sample is held, so that a full Cb/Cr pair is presented with every luma sample. Luma and chroma then pass through two independent delay lines with separately programmed lengths. Downstream processing receives aligned Y/Cb/Cr plus the running sample and line counts. A new delay setting is only applied at a horizontal sync edge, so a line is never split by a change in alignment.

Top module: `hd_input_align`

## Requirements
- R1: While `rst_n` is low, every output is zero. Leaving reset, the block treats both sync inputs as having been high, the timing-reset bit as having been low, the chroma phase as if the last sample were Cr, and both active delays as 0.
- R2: With `cfg_free_run`=0, `samp_cnt_o` counts up by one each clock and returns to 0 on the clock after it reaches the last sample of the line or any higher value. The sample total is SPL_1080_30 when `cfg_std_720`=0 and `cfg_rate_25`=0, SPL_1080_25 when `cfg_std_720`=0 and `cfg_rate_25`=1, and SPL_720 when `cfg_std_720`=1. `line_cnt_o` advances only on that return and wraps to 0 after line LPF_1080-1 or LPF_720-1. The syncs do not affect the counts.
- R3: With `cfg_free_run`=1, a clock on which `hsync_in` is low after having been high (a falling edge) makes `samp_cnt_o` read 0 one clock later and advances `line_cnt_o` by one. On every other clock `samp_cnt_o` increments.
- R4: With `cfg_free_run`=1, a vertical event makes `line_cnt_o` read 0 one clock later, with priority over R3. When `cfg_vert_is_vsync`=1, a vertical event is a high-to-low step of `vert_in`. When it is 0, `vert_in` is a field level and any change of it is an event.
- R5: A high-to-low step of `cfg_timing_rst` after it has been high clears both counts on the next clock, in either counter mode and with priority over R2 to R4. A level that stays high or stays low has no effect.
- R6: With `cfg_fmt_422`=1, the `c_in` sample taken on the clock of a horizontal falling edge is Cb when `cfg_cr_first`=0 and Cr when it is 1. The following samples alternate. Each sample replaces only its own component, and the other component keeps its last value.
- R7: With `cfg_fmt_422`=0, Cb is taken from `c_in` and Cr from `s_in` on every clock.
- R8: `y_o` and `pix_valid_o` equal the luma path input captured 1+DY clocks earlier, and `cb_o`/`cr_o` equal the split chroma captured 1+DC clocks earlier. DY and DC are the active delays, and a programmed value above MAX_DLY (4 by default) acts as MAX_DLY.
- R9: `cfg_y_dly` and `cfg_c_dly` become the active delays on the clock of a horizontal falling edge, in both counter modes. That clock's output already uses the new values, and changes between edges have no effect until then.
- R10: `pix_valid_o` is 1 for samples where blanking is inactive: `blank_in`=0 when `cfg_blank_high`=1, and `blank_in`=1 when `cfg_blank_high`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| y_in | input | DW | Luma samples |
| c_in | input | DW | Interleaved Cb/Cr (4:2:2) or Cb (4:4:4) |
| s_in | input | DW | Cr in 4:4:4 mode |
| hsync_in | input | 1 | Horizontal sync, falling edge is the line reference |
| vert_in | input | 1 | VSYNC or field level |
| blank_in | input | 1 | Blanking flag, polarity programmable |
| cfg_std_720 | input | 1 | 1: 720p totals, 0: 1080i totals |
| cfg_rate_25 | input | 1 | 1080i: 1 selects the 25 Hz line total |
| cfg_free_run | input | 1 | 1: counters follow syncs, 0: standard wrap |
| cfg_timing_rst | input | 1 | High then low clears the counters |
| cfg_vert_is_vsync | input | 1 | 1: vert_in is VSYNC, 0: field level |
| cfg_blank_high | input | 1 | 1: blank_in active high |
| cfg_fmt_422 | input | 1 | 1: interleaved chroma on c_in |
| cfg_cr_first | input | 1 | 1: first chroma sample after hsync edge is Cr |
| cfg_y_dly | input | 3 | Requested luma delay in clocks |
| cfg_c_dly | input | 3 | Requested chroma delay in clocks |
| y_o | output | DW | Aligned luma |
| cb_o | output | DW | Aligned Cb |
| cr_o | output | DW | Aligned Cr |
| pix_valid_o | output | 1 | Active-picture flag aligned with luma |
| samp_cnt_o | output | SAMP_W | Sample position in the line |
| line_cnt_o | output | LINE_W | Line position |

## Verification
Each input set is driven on the falling clock edge and captured on the next rising edge. The counts are due right after that edge. Luma and valid are due 1+DY rising edges after capture, and chroma 1+DC edges after capture. The delay in effect switches on the same edge that sees the horizontal falling edge. Every check is therefore taken on the falling edge that follows each rising edge. The expected data is read from a per-clock history of the values the bench itself captured, indexed back by the active delay of each path, so a result arriving one clock early or late is caught.

// File: rtl/hd_align_pkg.sv
package hd_align_pkg;

  typedef enum logic {
    CH_CB = 1'b0,
    CH_CR = 1'b1
  } chroma_kind_e;

  localparam int unsigned DLY_SEL_W = 3;

  // Limit a requested delay to the deepest tap that exists.
  function automatic logic [DLY_SEL_W-1:0] clamp_dly(input logic [DLY_SEL_W-1:0] req,
                                                     input int unsigned maxd);
    logic [DLY_SEL_W-1:0] res;
    if ({29'd0, req} > maxd) res = DLY_SEL_W'(maxd);
    else                     res = req;
    return res;
  endfunction

endpackage

// File: rtl/hd_timing_counters.sv
module hd_timing_counters #(
  parameter int unsigned SAMP_W      = 12,
  parameter int unsigned LINE_W      = 11,
  parameter int unsigned SPL_1080_30 = 2200,
  parameter int unsigned SPL_1080_25 = 2640,
  parameter int unsigned SPL_720     = 1650,
  parameter int unsigned LPF_1080    = 1125,
  parameter int unsigned LPF_720     = 750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_fall,
  input  logic              vert_evt,
  input  logic              tr_fall,
  input  logic              free_run,
  input  logic              std_720,
  input  logic              rate_25,
  output logic [SAMP_W-1:0] samp_cnt,
  output logic [LINE_W-1:0] line_cnt
);

  localparam logic [SAMP_W-1:0] LAST_S30 = SAMP_W'(SPL_1080_30 - 1);
  localparam logic [SAMP_W-1:0] LAST_S25 = SAMP_W'(SPL_1080_25 - 1);
  localparam logic [SAMP_W-1:0] LAST_S72 = SAMP_W'(SPL_720 - 1);
  localparam logic [LINE_W-1:0] LAST_L10 = LINE_W'(LPF_1080 - 1);
  localparam logic [LINE_W-1:0] LAST_L72 = LINE_W'(LPF_720 - 1);

  logic [SAMP_W-1:0] samp_q, samp_d, samp_last;
  logic [LINE_W-1:0] line_q, line_d, line_last;

  // Limits of the selected standard
  always_comb begin
    if (std_720) begin
      samp_last = LAST_S72;
      line_last = LAST_L72;
    end else begin
      samp_last = rate_25 ? LAST_S25 : LAST_S30;
      line_last = LAST_L10;
    end
  end

  // Next-state
  always_comb begin
    samp_d = samp_q;
    line_d = line_q;
    if (tr_fall) begin
      samp_d = '0;
      line_d = '0;
    end else if (free_run) begin
      samp_d = hs_fall ? '0 : samp_q + 1'b1;
      if (vert_evt)     line_d = '0;
      else if (hs_fall) line_d = line_q + 1'b1;
    end else begin
      if (samp_q >= samp_last) begin
        samp_d = '0;
        line_d = (line_q >= line_last) ? '0 : line_q + 1'b1;
      end else begin
        samp_d = samp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      line_q <= '0;
    end else begin
      samp_q <= samp_d;
      line_q <= line_d;
    end
  end

  assign samp_cnt = samp_q;
  assign line_cnt = line_q;

endmodule

// File: rtl/hd_chroma_demux.sv
module hd_chroma_demux
  import hd_align_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_fall,
  input  logic          fmt_422,
  input  logic          cr_first,
  input  logic          blank_high,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] c_in,
  input  logic [DW-1:0] s_in,
  input  logic          blank_in,
  output logic [DW-1:0] y_s1,
  output logic          vld_s1,
  output logic [DW-1:0] cb_s1,
  output logic [DW-1:0] cr_s1
);

  chroma_kind_e  kind_q, kind_now;
  logic [DW-1:0] y_q, cb_q, cr_q, cb_d, cr_d;
  logic          vld_q, vld_d;

  // Which component the current c_in sample carries
  always_comb begin
    if (hs_fall)              kind_now = chroma_kind_e'(cr_first);
    else if (kind_q == CH_CB) kind_now = CH_CR;
    else                      kind_now = CH_CB;
  end

  always_comb begin
    cb_d  = cb_q;
    cr_d  = cr_q;
    vld_d = blank_high ? ~blank_in : blank_in;
    if (!fmt_422) begin
      cb_d = c_in;
      cr_d = s_in;
    end else if (kind_now == CH_CB) begin
      cb_d = c_in;
    end else begin
      cr_d = c_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CH_CR;
      y_q    <= '0;
      vld_q  <= 1'b0;
      cb_q   <= '0;
      cr_q   <= '0;
    end else begin
      kind_q <= kind_now;
      y_q    <= y_in;
      vld_q  <= vld_d;
      cb_q   <= cb_d;
      cr_q   <= cr_d;
    end
  end

  assign y_s1   = y_q;
  assign vld_s1 = vld_q;
  assign cb_s1  = cb_q;
  assign cr_s1  = cr_q;

endmodule

// File: rtl/hd_delay_line.sv
module hd_delay_line
  import hd_align_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned MAXD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         din,
  input  logic [DLY_SEL_W-1:0] sel,
  output logic [W-1:0]         dout
);

  logic [W-1:0] stg [1:MAXD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= int'(MAXD); k++) stg[k] <= '0;
    end else begin
      stg[1] <= din;
      for (int k = 2; k <= int'(MAXD); k++) stg[k] <= stg[k-1];
    end
  end

  // Tap 0 is the input itself, already registered upstream
  always_comb begin
    dout = din;
    for (int k = 1; k <= int'(MAXD); k++) begin
      if (int'(sel) == k) dout = stg[k];
    end
  end

endmodule

// File: rtl/hd_input_align.sv
module hd_input_align
  import hd_align_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SAMP_W      = 12,
  parameter int unsigned LINE_W      = 11,
  parameter int unsigned SPL_1080_30 = 2200,
  parameter int unsigned SPL_1080_25 = 2640,
  parameter int unsigned SPL_720     = 1650,
  parameter int unsigned LPF_1080    = 1125,
  parameter int unsigned LPF_720     = 750,
  parameter int unsigned MAX_DLY     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        y_in,
  input  logic [DW-1:0]        c_in,
  input  logic [DW-1:0]        s_in,
  input  logic                 hsync_in,
  input  logic                 vert_in,
  input  logic                 blank_in,
  input  logic                 cfg_std_720,
  input  logic                 cfg_rate_25,
  input  logic                 cfg_free_run,
  input  logic                 cfg_timing_rst,
  input  logic                 cfg_vert_is_vsync,
  input  logic                 cfg_blank_high,
  input  logic                 cfg_fmt_422,
  input  logic                 cfg_cr_first,
  input  logic [2:0]           cfg_y_dly,
  input  logic [2:0]           cfg_c_dly,
  output logic [DW-1:0]        y_o,
  output logic [DW-1:0]        cb_o,
  output logic [DW-1:0]        cr_o,
  output logic                 pix_valid_o,
  output logic [SAMP_W-1:0]    samp_cnt_o,
  output logic [LINE_W-1:0]    line_cnt_o
);

  localparam int unsigned YW = DW + 1;
  localparam int unsigned CW = 2 * DW;

  logic hs_q, vt_q, tr_q;
  logic hs_fall, vert_evt, tr_fall;
  logic [DLY_SEL_W-1:0] ydly_q, cdly_q, ydly_d, cdly_d;

  // Edge detection on syncs and the timing-reset bit
  assign hs_fall  = hs_q & ~hsync_in;
  assign vert_evt = cfg_vert_is_vsync ? (vt_q & ~vert_in) : (vt_q ^ vert_in);
  assign tr_fall  = tr_q & ~cfg_timing_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vt_q <= 1'b1;
      tr_q <= 1'b0;
    end else begin
      hs_q <= hsync_in;
      vt_q <= vert_in;
      tr_q <= cfg_timing_rst;
    end
  end

  // Delay settings are taken only at a line start
  always_comb begin
    ydly_d = clamp_dly(cfg_y_dly, MAX_DLY);
    cdly_d = clamp_dly(cfg_c_dly, MAX_DLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ydly_q <= '0;
      cdly_q <= '0;
    end else if (hs_fall) begin
      ydly_q <= ydly_d;
      cdly_q <= cdly_d;
    end
  end

  hd_timing_counters #(
    .SAMP_W     (SAMP_W),
    .LINE_W     (LINE_W),
    .SPL_1080_30(SPL_1080_30),
    .SPL_1080_25(SPL_1080_25),
    .SPL_720    (SPL_720),
    .LPF_1080   (LPF_1080),
    .LPF_720    (LPF_720)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_fall (hs_fall),
    .vert_evt(vert_evt),
    .tr_fall (tr_fall),
    .free_run(cfg_free_run),
    .std_720 (cfg_std_720),
    .rate_25 (cfg_rate_25),
    .samp_cnt(samp_cnt_o),
    .line_cnt(line_cnt_o)
  );

  logic [DW-1:0] y_s1, cb_s1, cr_s1;
  logic          vld_s1;

  hd_chroma_demux #(.DW(DW)) u_demux (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_fall   (hs_fall),
    .fmt_422   (cfg_fmt_422),
    .cr_first  (cfg_cr_first),
    .blank_high(cfg_blank_high),
    .y_in      (y_in),
    .c_in      (c_in),
    .s_in      (s_in),
    .blank_in  (blank_in),
    .y_s1      (y_s1),
    .vld_s1    (vld_s1),
    .cb_s1     (cb_s1),
    .cr_s1     (cr_s1)
  );

  logic [YW-1:0] ypath_in, ypath_out;
  logic [CW-1:0] cpath_in, cpath_out;

  assign ypath_in = {vld_s1, y_s1};
  assign cpath_in = {cb_s1, cr_s1};

  hd_delay_line #(.W(YW), .MAXD(MAX_DLY)) u_ydly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ypath_in),
    .sel  (ydly_q),
    .dout (ypath_out)
  );

  hd_delay_line #(.W(CW), .MAXD(MAX_DLY)) u_cdly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cpath_in),
    .sel  (cdly_q),
    .dout (cpath_out)
  );

  assign pix_valid_o = ypath_out[YW-1];
  assign y_o         = ypath_out[DW-1:0];
  assign cb_o        = cpath_out[CW-1:DW];
  assign cr_o        = cpath_out[DW-1:0];

endmodule

// File: rtl/hd_input_align_chk.sv
module hd_input_align_chk #(
  parameter int unsigned SAMP_W = 12,
  parameter int unsigned LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_in,
  input logic              vert_in,
  input logic              cfg_free_run,
  input logic              cfg_timing_rst,
  input logic              cfg_vert_is_vsync,
  input logic [SAMP_W-1:0] samp_cnt_o,
  input logic [LINE_W-1:0] line_cnt_o
);

  // R2
  auto_samp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cfg_free_run && !($past(cfg_timing_rst) && !cfg_timing_rst))
    |=> (samp_cnt_o == '0 || samp_cnt_o == $past(samp_cnt_o) + 1'b1));

  // R2
  auto_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cfg_free_run && !($past(cfg_timing_rst) && !cfg_timing_rst))
    |=> (samp_cnt_o == '0 || $stable(line_cnt_o)));

  // R3
  hs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_free_run && $past(hsync_in) && !hsync_in)
    |=> (samp_cnt_o == '0));

  // R4
  vsync_line_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_free_run && cfg_vert_is_vsync && $past(vert_in) && !vert_in)
    |=> (line_cnt_o == '0));

  // R4
  field_line_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_free_run && !cfg_vert_is_vsync && (vert_in != $past(vert_in)))
    |=> (line_cnt_o == '0));

  // R5
  timing_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_timing_rst) && !cfg_timing_rst)
    |=> (samp_cnt_o == '0 && line_cnt_o == '0));

endmodule

bind hd_input_align hd_input_align_chk #(
  .SAMP_W(SAMP_W),
  .LINE_W(LINE_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .hsync_in         (hsync_in),
  .vert_in          (vert_in),
  .cfg_free_run     (cfg_free_run),
  .cfg_timing_rst   (cfg_timing_rst),
  .cfg_vert_is_vsync(cfg_vert_is_vsync),
  .samp_cnt_o       (samp_cnt_o),
  .line_cnt_o       (line_cnt_o)
);

// File: tb/hd_input_align_test.sv
`timescale 1ns/1ps
module hd_input_align_test;

  localparam int S30 = 12;
  localparam int S25 = 14;
  localparam int S72 = 9;
  localparam int L10 = 5;
  localparam int L72 = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  y_in, c_in, s_in;
  logic        hsync_in, vert_in, blank_in;
  logic        cfg_std_720, cfg_rate_25, cfg_free_run, cfg_timing_rst;
  logic        cfg_vert_is_vsync, cfg_blank_high, cfg_fmt_422, cfg_cr_first;
  logic [2:0]  cfg_y_dly, cfg_c_dly;
  logic [7:0]  y_o, cb_o, cr_o;
  logic        pix_valid_o;
  logic [11:0] samp_cnt_o;
  logic [10:0] line_cnt_o;

  hd_input_align #(
    .DW(8), .SAMP_W(12), .LINE_W(11),
    .SPL_1080_30(S30), .SPL_1080_25(S25), .SPL_720(S72),
    .LPF_1080(L10), .LPF_720(L72), .MAX_DLY(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .y_in(y_in), .c_in(c_in), .s_in(s_in),
    .hsync_in(hsync_in), .vert_in(vert_in), .blank_in(blank_in),
    .cfg_std_720(cfg_std_720), .cfg_rate_25(cfg_rate_25),
    .cfg_free_run(cfg_free_run), .cfg_timing_rst(cfg_timing_rst),
    .cfg_vert_is_vsync(cfg_vert_is_vsync), .cfg_blank_high(cfg_blank_high),
    .cfg_fmt_422(cfg_fmt_422), .cfg_cr_first(cfg_cr_first),
    .cfg_y_dly(cfg_y_dly), .cfg_c_dly(cfg_c_dly),
    .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .pix_valid_o(pix_valid_o),
    .samp_cnt_o(samp_cnt_o), .line_cnt_o(line_cnt_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side expectation state
  bit         m_hs, m_vt, m_tr, m_kind, m_v;
  logic [7:0] m_y, m_cb, m_cr;
  int         m_samp, m_line, m_yd, m_cd, n, since_dly;
  logic [8:0]  hy [64];
  logic [15:0] hc [64];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  function automatic int clampd(input logic [2:0] d);
    return (d > 3'd4) ? 4 : int'(d);
  endfunction

  task automatic cyc(input bit hs, input bit vt, input bit bl);
    bit    hf, ve, tf, kind;
    int    slast, llast, nyd, ncd;
    string ct, yt;
    y_in     = 8'(n * 37 + 11);
    c_in     = 8'(n * 53 + 7);
    s_in     = 8'(n * 29 + 90);
    hsync_in = hs;
    vert_in  = vt;
    blank_in = bl;
    hf = m_hs && !hs;
    ve = cfg_vert_is_vsync ? (m_vt && !vt) : (m_vt != vt);
    tf = m_tr && !cfg_timing_rst;
    m_hs = hs; m_vt = vt; m_tr = cfg_timing_rst;
    slast = cfg_std_720 ? S72 - 1 : (cfg_rate_25 ? S25 - 1 : S30 - 1);
    llast = cfg_std_720 ? L72 - 1 : L10 - 1;
    if (tf) begin
      m_samp = 0; m_line = 0; ct = "R5";
    end else if (cfg_free_run) begin
      if (ve)      m_line = 0;
      else if (hf) m_line = (m_line + 1) % 2048;
      m_samp = hf ? 0 : (m_samp + 1) % 4096;
      ct = ve ? "R4" : "R3";
    end else begin
      if (m_samp >= slast) begin
        m_samp = 0;
        m_line = (m_line >= llast) ? 0 : m_line + 1;
      end else begin
        m_samp = m_samp + 1;
      end
      ct = "R2";
    end
    kind   = hf ? cfg_cr_first : !m_kind;
    m_kind = kind;
    if (!cfg_fmt_422) begin m_cb = c_in; m_cr = s_in; end
    else if (kind)    m_cr = c_in;
    else              m_cb = c_in;
    m_y = y_in;
    m_v = cfg_blank_high ? !bl : bl;
    if (hf) begin
      nyd = clampd(cfg_y_dly);
      ncd = clampd(cfg_c_dly);
      if (nyd != m_yd || ncd != m_cd) since_dly = 0;
      m_yd = nyd; m_cd = ncd;
    end
    hy[n % 64] = {m_v, m_y};
    hc[n % 64] = {m_cb, m_cr};
    @(posedge clk);
    @(negedge clk);
    chk(ct, int'(samp_cnt_o), m_samp);
    chk(ct, int'(line_cnt_o), m_line);
    yt = (since_dly < 6 || clampd(cfg_y_dly) != m_yd) ? "R9" : "R8";
    chk(yt, int'(y_o), int'(hy[(n - m_yd) % 64][7:0]));
    chk("R10", int'(pix_valid_o), int'(hy[(n - m_yd) % 64][8]));
    chk(cfg_fmt_422 ? "R6" : "R7", int'({cb_o, cr_o}), int'(hc[(n - m_cd) % 64]));
    n++;
    since_dly++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    y_in = '0; c_in = '0; s_in = '0;
    hsync_in = 1'b1; vert_in = 1'b1; blank_in = 1'b0;
    cfg_std_720 = 0; cfg_rate_25 = 0; cfg_free_run = 1; cfg_timing_rst = 0;
    cfg_vert_is_vsync = 1; cfg_blank_high = 0; cfg_fmt_422 = 0; cfg_cr_first = 0;
    cfg_y_dly = 3'd0; cfg_c_dly = 3'd0;
    for (int i = 0; i < 64; i++) begin hy[i] = '0; hc[i] = '0; end
    m_hs = 1; m_vt = 1; m_tr = 0; m_kind = 1; m_v = 0;
    m_y = '0; m_cb = '0; m_cr = '0;
    m_samp = 0; m_line = 0; m_yd = 0; m_cd = 0; n = 64; since_dly = 100;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(y_o), 0);
    chk("R1", int'(cb_o), 0);
    chk("R1", int'(cr_o), 0);
    chk("R1", int'(pix_valid_o), 0);
    chk("R1", int'(samp_cnt_o), 0);
    chk("R1", int'(line_cnt_o), 0);
    rst_n = 1'b1;

    // Sweep of delay, chroma format and order with external sync counting
    for (int cfgi = 0; cfgi < 256; cfgi++) begin
      for (int ln = 0; ln < 2; ln++) begin
        for (int pos = 0; pos < 11; pos++) begin
          if (ln == 0 && pos == 6) begin
            cfg_y_dly      = 3'(cfgi);
            cfg_c_dly      = 3'(cfgi >> 3);
            cfg_fmt_422    = cfgi[6];
            cfg_cr_first   = cfgi[7];
            cfg_blank_high = cfgi[0] ^ cfgi[3];
          end
          cyc(pos >= 2, !(ln == 0 && pos < 2 && (cfgi % 4) == 0), pos < 3);
        end
      end
    end

    // Standard-limited counting for each line total, with timing reset
    cfg_free_run = 0;
    for (int sd = 0; sd < 3; sd++) begin
      cfg_std_720 = (sd == 2);
      cfg_rate_25 = (sd == 1);
      cfg_timing_rst = 1;
      for (int k = 0; k < 3; k++) cyc(k % 7 != 0, 1'b1, 1'b0);
      cfg_timing_rst = 0;
      for (int k = 0; k < 90; k++) cyc(k % 7 != 0, k % 23 != 0, k % 5 == 0);
    end
    // Timing reset pulse while counting from external syncs
    cfg_free_run = 1;
    cfg_timing_rst = 1;
    for (int k = 0; k < 4; k++) cyc(k != 1, 1'b1, 1'b0);
    cfg_timing_rst = 0;
    for (int k = 0; k < 10; k++) cyc(k % 6 != 0, 1'b1, 1'b0);

    // Field-level vertical input
    cfg_vert_is_vsync = 0;
    cfg_fmt_422 = 1;
    for (int k = 0; k < 80; k++) cyc(k % 8 >= 2, (k / 17) % 2 == 1, k % 9 < 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule